// File: doc/BRIEF.md
# Floating-Point Compare Condition Unit

This block judges a relation between two floating-point operands and records the verdict in a small condition-code register. Sixteen relational predicates are available. Each predicate is a combination of three outcomes (unordered, equal, less-than) plus a flag that says whether a quiet NaN counts as an invalid operation. The operands may be interpreted as one single-precision value, as one double-precision value, or as a pair of single-precision values packed into 64 bits. In the paired case both verdicts are written together into two adjacent condition bits.

A magnitude mode compares absolute values: the sign bit of every operand lane is forced to zero before the comparison. A requester presents the operands, the format, the predicate index, the condition-bit index and the magnitude bit along with a one-cycle request strobe. The condition register and the invalid cause flag update on the following clock edge. Only the addressed bit or bits change; all other condition bits keep their values.

Top module: `fp_cond_unit`

## Requirements
- R1: After a cycle with `rst` high, `cc_bits` is all zeros and `invalid_cause` is 0.
- R2: The predicate index is a 4-bit mask. Bit 0 makes the result true when the operands are unordered, bit 1 when they are equal, and bit 2 when operand A is less than operand B. Index order 0..15 is therefore f, un, eq, ueq, olt, ult, ole, ule, sf, ngle, seq, ngl, lt, nge, le, ngt. The result is registered on the clock edge that samples `req_valid`.
- R3: Ordering is numeric. +0 and -0 compare equal. Infinities order at the extremes, and denormals order by magnitude. If either operand is a NaN (exponent all ones, fraction nonzero), the pair is unordered and neither equal nor less.
- R4: With `fmt` = 0 (single), only bits 31:0 of each operand are compared, and bits 63:32 have no effect.
- R5: With `fmt` = 1 (double), all 64 bits form one double-precision operand (1 sign, 11 exponent, 52 fraction bits).
- R6: With `abs_mode` high, the sign bit of every operand lane (bit 31 for single, bit 63 for double, bits 31 and 63 for paired) is cleared before comparing.
- R7: With `fmt` = 2 (paired), the lane in bits 31:0 writes condition bit `cc_idx`, and the lane in bits 63:32 writes bit (`cc_idx`+1) modulo 8.
- R8: A request sets the addressed condition bit when the predicate holds and clears it when it does not. Every other condition bit keeps its value.
- R9: `invalid_cause` is set by a request when, in any compared lane, predicate bit 3 is high and an operand is any NaN, or an operand is a signalling NaN (NaN whose fraction MSB is 0). Otherwise the request clears it.
- R10: In a cycle without `req_valid`, `cc_bits` and `invalid_cause` hold their values, whatever the other inputs do.
- R11: A request with `fmt` = 3 changes no condition bit and clears `invalid_cause`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Compare request strobe |
| op_a | input | 64 | Operand A (single in 31:0, double in 63:0, paired in both halves) |
| op_b | input | 64 | Operand B, same layout |
| fmt | input | 2 | 0 single, 1 double, 2 paired single, 3 reserved |
| pred_idx | input | 4 | Predicate mask index |
| cc_idx | input | 3 | Condition bit to write (lower lane in paired mode) |
| abs_mode | input | 1 | Compare magnitudes only |
| cc_bits | output | 8 | Condition-code register |
| invalid_cause | output | 1 | Invalid-operation cause of the latest request |

## Verification
The assertions run on every cycle. They check that idle cycles leave the register and the flag untouched, that single and double requests disturb no bit beyond the addressed one, that reserved-format requests are inert, and that reset clears the state. Inside each lane they check that unordered, equal and less-than are mutually exclusive and that a signalling predicate on an unordered pair raises invalid. Only the bench's sweeps show the actual predicate values. Those sweeps cover signed zeros, infinities, denormals, quiet and signalling NaNs, magnitude mode, the paired wrap from bit 7 to bit 0, and the insensitivity of single format to the upper operand half.

// File: rtl/fpc_pkg.sv
package fpc_pkg;

  localparam int SP_W   = 32;
  localparam int SP_EXP = 8;
  localparam int DP_W   = 64;
  localparam int DP_EXP = 11;

  localparam logic [1:0] FMT_SINGLE = 2'd0;
  localparam logic [1:0] FMT_DOUBLE = 2'd1;
  localparam logic [1:0] FMT_PAIRED = 2'd2;
  localparam logic [1:0] FMT_RSVD   = 2'd3;

  // predicate index decoded as a mask; field order is behaviour
  typedef struct packed {
    logic sig;   // bit 3: quiet NaN also raises invalid
    logic lt;    // bit 2: true when less-than
    logic eq;    // bit 1: true when equal
    logic un;    // bit 0: true when unordered
  } pred_t;

  typedef struct packed {
    logic res;
    logic inv;
  } lane_out_t;

endpackage

// File: rtl/fpc_classify.sv
module fpc_classify #(
  parameter int W     = 32,
  parameter int EXP_W = 8
) (
  input  logic [W-2:0] mag,
  output logic         is_nan,
  output logic         is_snan,
  output logic         is_zero
);
  localparam int MAN_W = W - 1 - EXP_W;

  logic [EXP_W-1:0] expo;
  logic [MAN_W-1:0] frac;

  always_comb begin
    expo    = mag[W-2 -: EXP_W];
    frac    = mag[MAN_W-1:0];
    is_nan  = (&expo) && (|frac);
    is_snan = is_nan && !frac[MAN_W-1];
    is_zero = (mag == '0);
  end
endmodule

// File: rtl/fpc_relate.sv
module fpc_relate #(
  parameter int W     = 32,
  parameter int EXP_W = 8
) (
  input  logic [W-1:0] val_a,
  input  logic [W-1:0] val_b,
  output logic         unord,
  output logic         equal,
  output logic         less,
  output logic         any_nan,
  output logic         any_snan
);
  logic nan_a, snan_a, zero_a;
  logic nan_b, snan_b, zero_b;
  logic sa, sb, both_zero, mag_lt, mag_gt, same_bits;

  fpc_classify #(.W(W), .EXP_W(EXP_W)) u_cls_a (
    .mag(val_a[W-2:0]), .is_nan(nan_a), .is_snan(snan_a), .is_zero(zero_a)
  );
  fpc_classify #(.W(W), .EXP_W(EXP_W)) u_cls_b (
    .mag(val_b[W-2:0]), .is_nan(nan_b), .is_snan(snan_b), .is_zero(zero_b)
  );

  always_comb begin
    sa        = val_a[W-1];
    sb        = val_b[W-1];
    both_zero = zero_a && zero_b;
    mag_lt    = val_a[W-2:0] < val_b[W-2:0];
    mag_gt    = val_a[W-2:0] > val_b[W-2:0];
    same_bits = (val_a == val_b);
    any_nan   = nan_a || nan_b;
    any_snan  = snan_a || snan_b;
    unord     = any_nan;
    equal     = !any_nan && (same_bits || both_zero);
    less      = !any_nan && !both_zero &&
                ((sa && !sb) || (!sa && !sb && mag_lt) || (sa && sb && mag_gt));
  end
endmodule

// File: rtl/fpc_lane.sv
module fpc_lane
  import fpc_pkg::*;
#(
  parameter int W     = 32,
  parameter int EXP_W = 8
) (
  input  logic [W-1:0] val_a,
  input  logic [W-1:0] val_b,
  input  logic         abs_en,
  input  logic [3:0]   pred,
  output lane_out_t    out
);
  logic [W-1:0] a_eff, b_eff;
  logic unord, equal, less, any_nan, any_snan;
  pred_t pm;

  always_comb begin
    a_eff = {val_a[W-1] & ~abs_en, val_a[W-2:0]};
    b_eff = {val_b[W-1] & ~abs_en, val_b[W-2:0]};
  end

  fpc_relate #(.W(W), .EXP_W(EXP_W)) u_rel (
    .val_a(a_eff), .val_b(b_eff), .unord(unord), .equal(equal),
    .less(less), .any_nan(any_nan), .any_snan(any_snan)
  );

  always_comb begin
    pm      = pred_t'(pred);
    out.res = (pm.un && unord) || (pm.eq && equal) || (pm.lt && less);
    out.inv = any_snan || (pm.sig && any_nan);
  end

  // R3: outcomes of the relation are mutually exclusive
  always_comb begin
    p_rel_excl_r3: assert ($countones({unord, equal, less}) <= 1)
      else $error("relation outcomes overlap");
    // R9: signalling predicate on unordered pair always raises invalid
    p_sig_inv_r9: assert (!(pm.sig && unord) || out.inv)
      else $error("signalling predicate missed invalid");
  end
endmodule

// File: rtl/fp_cond_unit.sv
module fp_cond_unit
  import fpc_pkg::*;
#(
  parameter int CC_N = 8,
  localparam int CC_IDX_W = $clog2(CC_N)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                req_valid,
  input  logic [63:0]         op_a,
  input  logic [63:0]         op_b,
  input  logic [1:0]          fmt,
  input  logic [3:0]          pred_idx,
  input  logic [CC_IDX_W-1:0] cc_idx,
  input  logic                abs_mode,
  output logic [CC_N-1:0]     cc_bits,
  output logic                invalid_cause
);
  localparam int N_SP_LANES = DP_W / SP_W;

  lane_out_t sp_out [N_SP_LANES];
  lane_out_t dp_out;

  genvar g;
  generate
    for (g = 0; g < N_SP_LANES; g++) begin : g_sp
      fpc_lane #(.W(SP_W), .EXP_W(SP_EXP)) u_lane (
        .val_a (op_a[g*SP_W +: SP_W]),
        .val_b (op_b[g*SP_W +: SP_W]),
        .abs_en(abs_mode),
        .pred  (pred_idx),
        .out   (sp_out[g])
      );
    end
  endgenerate

  fpc_lane #(.W(DP_W), .EXP_W(DP_EXP)) u_dp (
    .val_a(op_a), .val_b(op_b), .abs_en(abs_mode), .pred(pred_idx), .out(dp_out)
  );

  logic [CC_N-1:0]     cc_q, cc_nxt;
  logic                inv_q, inv_nxt;
  logic [CC_IDX_W-1:0] idx_hi;

  always_comb begin
    idx_hi  = cc_idx + 1'b1;
    cc_nxt  = cc_q;
    inv_nxt = inv_q;
    if (req_valid) begin
      unique case (fmt)
        FMT_SINGLE: begin
          cc_nxt[cc_idx] = sp_out[0].res;
          inv_nxt        = sp_out[0].inv;
        end
        FMT_DOUBLE: begin
          cc_nxt[cc_idx] = dp_out.res;
          inv_nxt        = dp_out.inv;
        end
        FMT_PAIRED: begin
          cc_nxt[cc_idx] = sp_out[0].res;
          cc_nxt[idx_hi] = sp_out[N_SP_LANES-1].res;
          inv_nxt        = sp_out[0].inv || sp_out[N_SP_LANES-1].inv;
        end
        default: inv_nxt = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cc_q  <= '0;
      inv_q <= 1'b0;
    end else begin
      cc_q  <= cc_nxt;
      inv_q <= inv_nxt;
    end
  end

  assign cc_bits       = cc_q;
  assign invalid_cause = inv_q;

  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (cc_bits == '0) && !invalid_cause)
    else $error("reset did not clear state");

  p_idle_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> $stable(cc_bits) && $stable(invalid_cause))
    else $error("state moved without request");

  p_one_bit_r8: assert property (@(posedge clk) disable iff (rst)
    (req_valid && (fmt == FMT_SINGLE || fmt == FMT_DOUBLE)) |=>
      (((cc_bits ^ $past(cc_bits)) & ~(CC_N'(1) << $past(cc_idx))) == '0))
    else $error("unaddressed condition bit changed");

  p_rsvd_inert_r11: assert property (@(posedge clk) disable iff (rst)
    (req_valid && fmt == FMT_RSVD) |=> $stable(cc_bits) && !invalid_cause)
    else $error("reserved format altered state");
endmodule

// File: tb/tb_fp_cond_unit.sv
`timescale 1ns/1ps
module tb_fp_cond_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [63:0] op_a = '0;
  logic [63:0] op_b = '0;
  logic [1:0]  fmt = '0;
  logic [3:0]  pred_idx = '0;
  logic [2:0]  cc_idx = '0;
  logic        abs_mode = 1'b0;
  logic [7:0]  cc_bits;
  logic        invalid_cause;

  int n_chk = 0;
  int n_fail = 0;
  logic [7:0] exp_cc = '0;
  logic       exp_inv = 1'b0;
  bit         done = 1'b0;

  always #4 clk = ~clk;

  fp_cond_unit dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .op_a(op_a), .op_b(op_b),
    .fmt(fmt), .pred_idx(pred_idx), .cc_idx(cc_idx), .abs_mode(abs_mode),
    .cc_bits(cc_bits), .invalid_cause(invalid_cause)
  );

  function automatic logic [31:0] sp_val(input int i);
    case (i)
      0: return 32'h0000_0000;  1: return 32'h8000_0000;
      2: return 32'h3F80_0000;  3: return 32'hBF80_0000;
      4: return 32'h4000_0000;  5: return 32'hC000_0000;
      6: return 32'h7F80_0000;  7: return 32'hFF80_0000;
      8: return 32'h7FC0_0000;  9: return 32'h7F80_0001;
      10: return 32'h0000_0001; default: return 32'hFF7F_FFFF;
    endcase
  endfunction

  function automatic logic [63:0] dp_val(input int i);
    case (i)
      0: return 64'h0000_0000_0000_0000; 1: return 64'h8000_0000_0000_0000;
      2: return 64'h3FF0_0000_0000_0000; 3: return 64'hBFF0_0000_0000_0000;
      4: return 64'h4000_0000_0000_0000; 5: return 64'h7FF0_0000_0000_0000;
      6: return 64'hFFF0_0000_0000_0000; 7: return 64'h7FF8_0000_0000_0000;
      8: return 64'hFFF0_0000_0000_0001; default: return 64'h0000_0000_0000_0001;
    endcase
  endfunction

  // returns {invalid, result} computed from signed ordering keys
  function automatic logic [1:0] model(input logic [63:0] a, input logic [63:0] b,
                                       input bit dbl, input logic [3:0] p, input bit ab);
    logic signed [64:0] ka, kb;
    bit na, nb, sna, snb, un, eq, lt, r, inv;
    if (dbl) begin
      if (ab) begin a[63] = 1'b0; b[63] = 1'b0; end
      na  = (a[62:52] == 11'h7FF) && (a[51:0] != 0);
      nb  = (b[62:52] == 11'h7FF) && (b[51:0] != 0);
      sna = na && !a[51];
      snb = nb && !b[51];
      ka  = a[63] ? -$signed({2'b00, a[62:0]}) : $signed({2'b00, a[62:0]});
      kb  = b[63] ? -$signed({2'b00, b[62:0]}) : $signed({2'b00, b[62:0]});
    end else begin
      if (ab) begin a[31] = 1'b0; b[31] = 1'b0; end
      na  = (a[30:23] == 8'hFF) && (a[22:0] != 0);
      nb  = (b[30:23] == 8'hFF) && (b[22:0] != 0);
      sna = na && !a[22];
      snb = nb && !b[22];
      ka  = a[31] ? -$signed({34'd0, a[30:0]}) : $signed({34'd0, a[30:0]});
      kb  = b[31] ? -$signed({34'd0, b[30:0]}) : $signed({34'd0, b[30:0]});
    end
    un  = na || nb;
    eq  = !un && (ka == kb);
    lt  = !un && (ka < kb);
    r   = (p[0] && un) || (p[1] && eq) || (p[2] && lt);
    inv = sna || snb || (p[3] && un);
    return {inv, r};
  endfunction

  task automatic check(input bit ok, input string tag, input logic [7:0] act,
                       input logic [7:0] expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  task automatic compare(input string tag);
    check(cc_bits === exp_cc, tag, cc_bits, exp_cc);
    check(invalid_cause === exp_inv, tag, {7'd0, invalid_cause}, {7'd0, exp_inv});
  endtask

  task automatic issue(input logic [63:0] a, input logic [63:0] b, input logic [1:0] f,
                       input logic [3:0] p, input logic [2:0] s, input bit ab);
    @(negedge clk);
    op_a = a; op_b = b; fmt = f; pred_idx = p; cc_idx = s; abs_mode = ab;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  initial begin
    logic [1:0] m, mh;
    logic [63:0] a, b;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    compare("R1 reset state");

    // R2 R3 R4 R6 R8 R9: single sweep, upper half holds junk
    for (int i = 0; i < 12; i++)
      for (int j = 0; j < 12; j++)
        for (int p = 0; p < 16; p++)
          for (int ab = 0; ab < 2; ab++) begin
            a = {32'hDEAD_0000 ^ 32'(i * 77 + p), sp_val(i)};
            b = {32'h7FC0_0000 ^ 32'(j * 13 + ab), sp_val(j)};
            m = model({32'd0, sp_val(i)}, {32'd0, sp_val(j)}, 1'b0, 4'(p), ab[0]);
            issue(a, b, 2'd0, 4'(p), 3'(i + j + p), ab[0]);
            exp_cc[3'(i + j + p)] = m[0];
            exp_inv = m[1];
            compare("R2/R3/R4/R6/R8/R9 single");
          end

    // R5 R6 R9: double sweep
    for (int i = 0; i < 10; i++)
      for (int j = 0; j < 10; j++)
        for (int p = 0; p < 16; p++)
          for (int ab = 0; ab < 2; ab++) begin
            m = model(dp_val(i), dp_val(j), 1'b1, 4'(p), ab[0]);
            issue(dp_val(i), dp_val(j), 2'd1, 4'(p), 3'(i * 3 + j + ab), ab[0]);
            exp_cc[3'(i * 3 + j + ab)] = m[0];
            exp_inv = m[1];
            compare("R5/R6/R9 double");
          end

    // R7 R6 R9: paired sweep, including wrap from bit 7 to bit 0
    for (int i = 0; i < 12; i++)
      for (int j = 0; j < 12; j++)
        for (int p = 0; p < 16; p++)
          for (int ab = 0; ab < 2; ab++) begin
            a = {sp_val((i + 5) % 12), sp_val(i)};
            b = {sp_val((j * 7 + 3) % 12), sp_val(j)};
            m  = model({32'd0, a[31:0]},  {32'd0, b[31:0]},  1'b0, 4'(p), ab[0]);
            mh = model({32'd0, a[63:32]}, {32'd0, b[63:32]}, 1'b0, 4'(p), ab[0]);
            issue(a, b, 2'd2, 4'(p), 3'(i + p), ab[0]);
            exp_cc[3'(i + p)]     = m[0];
            exp_cc[3'(i + p + 1)] = mh[0];
            exp_inv = m[1] | mh[1];
            compare("R7 paired");
          end

    // R10: idle cycles with changing inputs
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      op_a = dp_val(k % 10); op_b = dp_val((k + 3) % 10);
      fmt = 2'(k); pred_idx = 4'(k); cc_idx = 3'(k); abs_mode = k[0];
      @(negedge clk);
      compare("R10 idle hold");
    end

    // R11: reserved format after an invalid-raising request
    issue({32'd0, sp_val(9)}, '0, 2'd0, 4'd0, 3'd2, 1'b0);
    exp_cc[2] = 1'b0; exp_inv = 1'b1;
    compare("R9 snan single");
    issue({32'd0, sp_val(2)}, {32'd0, sp_val(2)}, 2'd3, 4'd2, 3'd2, 1'b0);
    exp_inv = 1'b0;
    compare("R11 reserved");

    // R1: reset mid-run clears
    @(negedge clk); rst = 1'b1; @(negedge clk); rst = 1'b0;
    exp_cc = '0; exp_inv = 1'b0;
    compare("R1 reset again");
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        #1600000;
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=%h expected=%h", 8'h00, 8'h01);
      end
    join_any
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule